// File: doc/BRIEF.md
# Serial Link Frame Deframer

This block recovers frames from a single-lane serial link made of a forwarded link clock and one data line. A faster system clock oversamples both wires. Every change of level on the synchronised link clock, rising or falling, counts as one bit time, and the data level seen at that moment is taken as the bit. Every field is sent most significant bit first. While the receiver is idle it hunts for the start marker 1001. It then reads a 4-bit type code, which tells it whether a user-data byte, a run of payload words and a CRC byte come next. After those it reads a 4-bit tag and checks the end marker 0110.

A mode input selects a compatibility setting in which no preamble is sent. In the normal setting the receiver accepts a start marker only once it has seen a flush of at least four high bits. The received type, tag, user data, word count and payload words are presented on registered outputs. They change only when a frame ends with a correct end marker. Three single-cycle flags report the end of a frame, a CRC mismatch and a framing fault.

Top module: `serial_frame_deframer`

## Requirements
- R1: After reset, all received-field outputs (type, tag, user data, word count, payload words) are zero and frame_done, crc_err and frame_err are low.
- R2: Each change of the synchronised link clock, in either direction, captures exactly one bit from the data line. Every field is assembled most significant bit first.
- R3: With spi_mode low, a start marker is accepted only after at least four consecutive high bits have been seen since reset or since the receiver last went back to hunting, so a frame sent with no preamble is ignored. With spi_mode high, no preamble is needed.
- R4: A frame begins when the last four bits captured while hunting are 1001. Bits that come before the marker, including partial patterns such as 1010, are discarded.
- R5: Type code 0x3 is a ping frame: only the tag and the end marker follow the type. Type codes 0x8, 0x9, 0xA, 0xB and 0xC are data frames carrying 1, 2, 4, 8 and 16 words (never more than MAX_WORDS). In a data frame the order after the type is: user data (UD_W bits), the words, the CRC byte, the tag, and the end marker.
- R6: Payload words land in arrival order. The first word goes to rx_words[WORD_W-1:0], and each later word occupies the next WORD_W bits up. rx_nwords gives the count. Word slots at or above the count keep their earlier values.
- R7: The receiver computes a CRC-8 (polynomial 0x07, initial value 0x00, most significant bit first) over all payload bits. If the received CRC byte differs, crc_err pulses together with frame_done, and the fields still update.
- R8: The tag is stored for both ping and data frames. A ping frame sets rx_nwords to 0 and leaves rx_udata and rx_words unchanged.
- R9: If the four bits after the tag are not 0110, frame_done and frame_err pulse together and no received field changes.
- R10: A type code not listed in R5 aborts the frame at once. frame_err pulses without frame_done, no field changes, and the receiver goes back to hunting, so the next valid frame is received.
- R11: frame_done is a single-cycle pulse, raised once per frame after the last end-marker bit. crc_err is never high without frame_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_mode | input | 1 | High: no preamble is expected before the start marker |
| lnk_clk | input | 1 | Forwarded link clock; high when idle |
| lnk_dat | input | 1 | Serial data line; high when idle |
| rx_type | output | 4 | Type code of the last accepted frame |
| rx_udata | output | UD_W | User data of the last accepted data frame |
| rx_tag | output | 4 | Tag of the last accepted frame |
| rx_nwords | output | $clog2(MAX_WORDS+1) | Word count of the last accepted frame (0 for ping) |
| rx_words | output | MAX_WORDS*WORD_W | Payload buffer; word 0 in the lowest bits |
| frame_done | output | 1 | One-cycle pulse after the end marker |
| crc_err | output | 1 | One-cycle pulse with frame_done on a CRC mismatch |
| frame_err | output | 1 | One-cycle pulse on a bad end marker or an undefined type |

## Verification
The hardest conditions to reach from the ports concern the hunting logic. One is a normal-mode frame with no flush bits, which must be ignored. The other is a start marker buried in noise, which must still be found. The bench reaches the first straight after reset, before any high run can arm the receiver, by sending a ping frame whose bits never contain four ones in a row. For the second it sends a flush, then the decoy 1010, then the true marker. For an aborted undefined type, the bench chooses the trailing tag bits so that the hunter cannot find a false 1001 in what follows. The run then continues to a valid frame to show that the receiver recovers.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_TYPE,
      ST_UDATA,
      ST_DATA,
      ST_CRC,
      ST_TAG,
      ST_EOF
   } rx_state_t;

   typedef struct packed {
      logic       valid;
      logic       has_payload;
      logic [4:0] nwords;
   } kind_t;

   localparam logic [3:0] SOF_MARK       = 4'b1001;
   localparam logic [3:0] EOF_MARK       = 4'b0110;
   localparam logic [3:0] CODE_PING      = 4'h3;
   localparam logic [3:0] CODE_DATA_BASE = 4'h8;
   localparam logic [3:0] CODE_DATA_TOP  = 4'hC;

   // A data code encodes log2 of its word count as an offset from the base.
   function automatic kind_t decode_kind(input logic [3:0] code,
                                         input int unsigned max_words);
      kind_t       k;
      int unsigned n;
      k = '0;
      if (code == CODE_PING) begin
         k.valid = 1'b1;
      end else if (code >= CODE_DATA_BASE && code <= CODE_DATA_TOP) begin
         n = 32'd1 << (code - CODE_DATA_BASE);
         if (n <= max_words) begin
            k.valid       = 1'b1;
            k.has_payload = 1'b1;
            k.nwords      = 5'(n);
         end
      end
      return k;
   endfunction

endpackage

// File: rtl/sfd_sampler.sv
module sfd_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lnk_clk,
   input  logic lnk_dat,
   output logic bit_edge,
   output logic bit_val
);
   logic ck_s;
   logic ck_prev;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_s    <= 1'b1;
               bit_val <= 1'b1;
            end else begin
               ck_s    <= lnk_clk;
               bit_val <= lnk_dat;
            end
         end
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] ck_sh;
         logic [SYNC_STAGES-1:0] dt_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_sh <= '1;
               dt_sh <= '1;
            end else begin
               ck_sh <= {ck_sh[SYNC_STAGES-2:0], lnk_clk};
               dt_sh <= {dt_sh[SYNC_STAGES-2:0], lnk_dat};
            end
         end
         assign ck_s    = ck_sh[SYNC_STAGES-1];
         assign bit_val = dt_sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_prev <= 1'b1;
      else        ck_prev <= ck_s;
   end

   assign bit_edge = ck_s ^ ck_prev;

endmodule

// File: rtl/sfd_start_hunt.sv
module sfd_start_hunt
   import sfd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic spi_mode,
   input  logic hunting,
   input  logic clear,
   input  logic bit_edge,
   input  logic bit_val,
   output logic start
);
   logic [3:0] hist;
   logic [2:0] ones;
   logic       armed;
   logic [3:0] hist_next;

   assign hist_next = {hist[2:0], bit_val};
   assign start     = bit_edge && hunting && (hist_next == SOF_MARK) && (spi_mode || armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist  <= 4'b1111;
         ones  <= '0;
         armed <= 1'b0;
      end else if (clear) begin
         hist  <= 4'b1111;
         ones  <= '0;
         armed <= 1'b0;
      end else if (bit_edge && hunting) begin
         hist <= hist_next;
         if (!bit_val)         ones <= '0;
         else if (ones != 3'd4) ones <= ones + 3'd1;
         if (bit_val && ones == 3'd3) armed <= 1'b1;
      end
   end

   // R3: the high-run counter never passes its ceiling
   p_ones_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= 3'd4);

endmodule

// File: rtl/sfd_crc8.sv
module sfd_crc8 #(
   parameter logic [7:0] POLY = 8'h07,
   parameter logic [7:0] INIT = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       en,
   input  logic       din,
   output logic [7:0] crc
);
   logic fb;
   assign fb = crc[7] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= INIT;
      else if (clear) crc <= INIT;
      else if (en)    crc <= {crc[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
   end

endmodule

// File: rtl/serial_frame_deframer.sv
module serial_frame_deframer
   import sfd_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int UD_W        = 8,
   parameter int MAX_WORDS   = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NW_W       = $clog2(MAX_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        spi_mode,
   input  logic                        lnk_clk,
   input  logic                        lnk_dat,
   output logic [3:0]                  rx_type,
   output logic [UD_W-1:0]             rx_udata,
   output logic [3:0]                  rx_tag,
   output logic [NW_W-1:0]             rx_nwords,
   output logic [MAX_WORDS*WORD_W-1:0] rx_words,
   output logic                        frame_done,
   output logic                        crc_err,
   output logic                        frame_err
);
   localparam int FW    = (WORD_W > UD_W) ? WORD_W : UD_W;
   localparam int CNT_W = $clog2(FW);
   localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

   generate
      if (MAX_WORDS < 1 || MAX_WORDS > 16) begin : g_chk_words
         $error("MAX_WORDS must lie in 1..16");
      end
      if (WORD_W < 8) begin : g_chk_width
         $error("WORD_W must be at least 8");
      end
      if (UD_W < 4) begin : g_chk_ud
         $error("UD_W must be at least 4");
      end
   endgenerate

   logic bit_edge, bit_val, start;
   logic [7:0] crc_val;

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [FW-2:0]    sreg;
   logic [FW-1:0]    fw_next;
   logic [3:0]       nib;
   logic [IDX_W-1:0] widx;
   logic             kind_pay;
   logic [4:0]       kind_nw;
   logic [3:0]       stg_type, stg_tag;
   logic [UD_W-1:0]  stg_ud;
   logic             crc_bad;
   logic             done_q, ferr_q, cerr_q;
   kind_t            dec;
   int               len;
   logic             last, commit, to_hunt, wr_word;

   sfd_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_dat(lnk_dat),
      .bit_edge(bit_edge), .bit_val(bit_val));

   sfd_start_hunt u_hunt (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode),
      .hunting(state == ST_HUNT), .clear(to_hunt),
      .bit_edge(bit_edge), .bit_val(bit_val), .start(start));

   sfd_crc8 #(.POLY(8'h07), .INIT(8'h00)) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(start),
      .en(bit_edge && state == ST_DATA), .din(bit_val), .crc(crc_val));

   assign fw_next = {sreg, bit_val};
   assign nib     = fw_next[3:0];
   assign dec     = decode_kind(nib, MAX_WORDS);

   always_comb begin
      case (state)
         ST_UDATA: len = UD_W;
         ST_DATA:  len = WORD_W;
         ST_CRC:   len = 8;
         ST_HUNT:  len = 1;
         default:  len = 4;
      endcase
   end

   assign last    = (int'(cnt) == len - 1);
   assign wr_word = bit_edge && state == ST_DATA && last;
   assign commit  = bit_edge && state == ST_EOF && last && nib == EOF_MARK;
   assign to_hunt = bit_edge && last &&
                    ((state == ST_TYPE && !dec.valid) || state == ST_EOF);

   // Frame sequencer: one step per captured bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_HUNT;
         cnt      <= '0;
         sreg     <= '0;
         widx     <= '0;
         kind_pay <= 1'b0;
         kind_nw  <= '0;
         stg_type <= '0;
         stg_tag  <= '0;
         stg_ud   <= '0;
         crc_bad  <= 1'b0;
         done_q   <= 1'b0;
         ferr_q   <= 1'b0;
         cerr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ferr_q <= 1'b0;
         cerr_q <= 1'b0;
         if (bit_edge) begin
            if (state == ST_HUNT) begin
               if (start) begin
                  state   <= ST_TYPE;
                  cnt     <= '0;
                  sreg    <= '0;
                  crc_bad <= 1'b0;
               end
            end else begin
               sreg <= fw_next[FW-2:0];
               cnt  <= last ? '0 : cnt + 1'b1;
               if (last) begin
                  case (state)
                     ST_TYPE: begin
                        stg_type <= nib;
                        kind_pay <= dec.has_payload;
                        kind_nw  <= dec.nwords;
                        if (!dec.valid) begin
                           state  <= ST_HUNT;
                           ferr_q <= 1'b1;
                        end else if (dec.has_payload) begin
                           state <= ST_UDATA;
                        end else begin
                           state <= ST_TAG;
                        end
                     end
                     ST_UDATA: begin
                        stg_ud <= fw_next[UD_W-1:0];
                        widx   <= '0;
                        state  <= ST_DATA;
                     end
                     ST_DATA: begin
                        if (widx == IDX_W'(kind_nw - 5'd1)) state <= ST_CRC;
                        else                                widx  <= widx + 1'b1;
                     end
                     ST_CRC: begin
                        crc_bad <= (fw_next[7:0] != crc_val);
                        state   <= ST_TAG;
                     end
                     ST_TAG: begin
                        stg_tag <= nib;
                        state   <= ST_EOF;
                     end
                     ST_EOF: begin
                        done_q <= 1'b1;
                        ferr_q <= (nib != EOF_MARK);
                        cerr_q <= crc_bad;
                        state  <= ST_HUNT;
                     end
                     default: state <= ST_HUNT;
                  endcase
               end
            end
         end
      end
   end

   // Committed scalar fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_type   <= '0;
         rx_tag    <= '0;
         rx_udata  <= '0;
         rx_nwords <= '0;
      end else if (commit) begin
         rx_type   <= stg_type;
         rx_tag    <= stg_tag;
         if (kind_pay) rx_udata <= stg_ud;
         rx_nwords <= kind_pay ? NW_W'(kind_nw) : '0;
      end
   end

   // Per-word staging and committed copies
   generate
      for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_word
         localparam logic [4:0]       SLOT = 5'(gi);
         localparam logic [IDX_W-1:0] WIX  = IDX_W'(gi);
         logic [WORD_W-1:0] stg_w, out_w;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_w <= '0;
               out_w <= '0;
            end else begin
               if (wr_word && widx == WIX) stg_w <= fw_next[WORD_W-1:0];
               if (commit && kind_pay && SLOT < kind_nw) out_w <= stg_w;
            end
         end
         assign rx_words[gi*WORD_W +: WORD_W] = out_w;
      end
   endgenerate

   assign frame_done = done_q;
   assign frame_err  = ferr_q;
   assign crc_err    = cerr_q;

   // R11: completion is a one-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R7 / R11: a CRC fault is only reported at frame completion
   p_crc_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> frame_done);

   // R9: the tag output moves only on a clean completion
   p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_tag) |-> (frame_done && !frame_err));

   // R9: the type output moves only on a clean completion
   p_type_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_type) |-> (frame_done && !frame_err));

   // R10: a framing error without completion can only follow the type phase
   p_abort_from_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && !frame_done) |-> ($past(state) == ST_TYPE));

   // R6: the word index stays inside the announced count
   p_word_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> (5'(widx) < kind_nw));

endmodule

// File: tb/tb_serial_frame_deframer.sv
`timescale 1ns/1ps
module tb_serial_frame_deframer;
   localparam int WORD_W = 16;
   localparam int UD_W = 8;
   localparam int MAX_WORDS = 16;
   localparam int NW_W = $clog2(MAX_WORDS + 1);
   localparam int BUF_W = MAX_WORDS * WORD_W;

   typedef struct packed {
      logic        spi;
      logic [3:0]  code;
      logic [7:0]  ud;
      logic [15:0] seed;
      logic [3:0]  tag;
      logic [3:0]  eof;
      logic [7:0]  cx;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'h3, 8'h00, 16'h0000, 4'hA, 4'h6, 8'h00},  // ping, R5 R8
      '{1'b0, 4'h8, 8'h5C, 16'h1234, 4'h3, 4'h6, 8'h00},  // 1 word, R6
      '{1'b0, 4'h9, 8'hA1, 16'hBEEF, 4'h5, 4'h6, 8'h00},  // 2 words
      '{1'b1, 4'hA, 8'h33, 16'h0F0F, 4'hC, 4'h6, 8'h00},  // spi, 4 words, R3
      '{1'b1, 4'hC, 8'hFE, 16'h8001, 4'h7, 4'h6, 8'h00},  // 16 words
      '{1'b0, 4'hB, 8'h42, 16'h7777, 4'h1, 4'h6, 8'h5A},  // bad crc, R7
      '{1'b0, 4'h9, 8'h99, 16'h4321, 4'hE, 4'h7, 8'h00},  // bad eof, R9
      '{1'b1, 4'h3, 8'h00, 16'h0000, 4'h9, 4'h6, 8'h00},  // ping keeps data, R8
      '{1'b0, 4'h5, 8'h00, 16'h0000, 4'h0, 4'h6, 8'h00},  // undefined, R10
      '{1'b1, 4'hD, 8'h00, 16'h0000, 4'h0, 4'h6, 8'h00},  // undefined, R10
      '{1'b0, 4'h8, 8'h17, 16'hCAFE, 4'h4, 4'h6, 8'h00}   // recovery, R10
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_mode = 1'b0;
   logic lnk_clk = 1'b1;
   logic lnk_dat = 1'b1;
   logic [3:0] rx_type, rx_tag;
   logic [UD_W-1:0] rx_udata;
   logic [NW_W-1:0] rx_nwords;
   logic [BUF_W-1:0] rx_words;
   logic frame_done, crc_err, frame_err;

   int checks = 0, errors = 0;
   int n_done = 0, n_ferr = 0, n_cerr = 0;
   logic [3:0] e_type = '0, e_tag = '0;
   logic [7:0] e_ud = '0;
   int e_nw = 0;
   logic [BUF_W-1:0] e_words = '0;

   always #2 clk = ~clk;

   serial_frame_deframer dut (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode),
      .lnk_clk(lnk_clk), .lnk_dat(lnk_dat),
      .rx_type(rx_type), .rx_udata(rx_udata), .rx_tag(rx_tag),
      .rx_nwords(rx_nwords), .rx_words(rx_words),
      .frame_done(frame_done), .crc_err(crc_err), .frame_err(frame_err));

   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_done) n_done++;
         if (frame_err)  n_ferr++;
         if (crc_err)    n_cerr++;
      end
   end

   task automatic chk(input string rq, input logic [BUF_W-1:0] act, input logic [BUF_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int words_of(input logic [3:0] code);
      if (code >= 4'h8 && code <= 4'hC) return 1 << (code - 4'h8);
      return 0;
   endfunction

   function automatic bit code_ok(input logic [3:0] code);
      return (code == 4'h3) || (code >= 4'h8 && code <= 4'hC);
   endfunction

   function automatic logic [15:0] wgen(input logic [15:0] seed, input int k);
      return seed + 16'(k) * 16'h0F1D;
   endfunction

   function automatic logic [7:0] crc_of(input logic [15:0] seed, input int n);
      logic [7:0] c = 8'h00;
      for (int k = 0; k < n; k++) begin
         logic [15:0] w = wgen(seed, k);
         for (int b = 15; b >= 0; b--) begin
            logic f = c[7] ^ w[b];
            c = {c[6:0], 1'b0};
            if (f) c = c ^ 8'h07;
         end
      end
      return c;
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk);
      lnk_dat = b;
      repeat (2) @(negedge clk);
      lnk_clk = ~lnk_clk;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_frame(input logic [3:0] code, input logic [7:0] ud,
                             input logic [15:0] seed, input logic [3:0] tag,
                             input logic [3:0] eof, input logic [7:0] cx,
                             input bit pre, input bit post);
      int n = words_of(code);
      if (pre) send_bits(32'hF, 4);
      send_bits(32'h9, 4);
      send_bits({28'd0, code}, 4);
      if (n > 0) begin
         send_bits({24'd0, ud}, 8);
         for (int k = 0; k < n; k++) send_bits({16'd0, wgen(seed, k)}, 16);
         send_bits({24'd0, crc_of(seed, n) ^ cx}, 8);
      end
      send_bits({28'd0, tag}, 4);
      send_bits({28'd0, eof}, 4);
      if (post) send_bits(32'hF, 4);
      repeat (10) @(negedge clk);
      lnk_dat = 1'b1;
   endtask

   task automatic check_fields(input string rq);
      chk({rq, " type"},   BUF_W'(rx_type),   BUF_W'(e_type));
      chk({rq, " tag"},    BUF_W'(rx_tag),    BUF_W'(e_tag));
      chk({rq, " udata"},  BUF_W'(rx_udata),  BUF_W'(e_ud));
      chk({rq, " nwords"}, BUF_W'(rx_nwords), BUF_W'(e_nw));
      chk({rq, " words"},  rx_words,          e_words);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int d0, f0, c0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      check_fields("R1 reset");
      chk("R1 flags", BUF_W'({frame_done, crc_err, frame_err}), '0);

      // R3: normal mode, no preamble since reset -> frame ignored
      spi_mode = 1'b0;
      d0 = n_done;
      send_frame(4'h3, 8'h00, 16'h0, 4'h2, 4'h6, 8'h00, 1'b0, 1'b0);
      chk("R3 no preamble ignored", BUF_W'(n_done - d0), '0);
      chk("R3 tag untouched", BUF_W'(rx_tag), '0);

      // R4 / R2: flush, decoy 1010, then true marker
      d0 = n_done;
      send_bits(32'hF, 4);
      send_bits(32'hA, 4);
      send_frame(4'h3, 8'h00, 16'h0, 4'h6, 4'h6, 8'h00, 1'b0, 1'b1);
      e_type = 4'h3; e_tag = 4'h6; e_nw = 0;
      chk("R4 resync done count", BUF_W'(n_done - d0), BUF_W'(1));
      check_fields("R4 R2 resync");

      // Table walk
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         bit ok = code_ok(t.code);
         int n = words_of(t.code);
         spi_mode = t.spi;
         d0 = n_done; f0 = n_ferr; c0 = n_cerr;
         send_frame(t.code, t.ud, t.seed, t.tag, t.eof, t.cx, !t.spi, !t.spi);
         if (ok && t.eof == 4'h6) begin
            e_type = t.code; e_tag = t.tag; e_nw = n;
            if (n > 0) begin
               e_ud = t.ud;
               for (int k = 0; k < n; k++) e_words[k*WORD_W +: WORD_W] = wgen(t.seed, k);
            end
         end
         chk($sformatf("R11 R10 vec%0d done", v), BUF_W'(n_done - d0), BUF_W'(ok ? 1 : 0));
         chk($sformatf("R9 R10 vec%0d frame_err", v), BUF_W'(n_ferr - f0),
             BUF_W'((!ok || t.eof != 4'h6) ? 1 : 0));
         chk($sformatf("R7 vec%0d crc_err", v), BUF_W'(n_cerr - c0),
             BUF_W'((ok && n > 0 && t.cx != 8'h00) ? 1 : 0));
         check_fields($sformatf("R5 R6 R8 vec%0d", v));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule